// File: doc/BRIEF.md
# Round-Robin DMA Channel Scheduler

This block picks at most one DMA channel to service each time it is started. Eight channel slots are spread over two cascaded four-channel controllers and are treated as one ring. A rotating pointer marks where the next search begins. The search walks forward from the pointer one slot per clock. It stops at the first slot that is eligible for service, or after a full lap with nothing found.

The block also holds the per-channel acknowledge bits for single and block mode. A slot's acknowledge bit is set when the scan meets an unmasked hardware request there. The bit is cleared when a terminal count is reported for that slot.

A transfer engine pulses `start_i` once per service tick and waits for `done_o`. Then it either moves data for `sel_o` (when `grant_o` is high) or idles. The transfer engine itself, along with the address and count arithmetic and the register decode, sits outside this block.

Top module: `dma_rr_sched`

## Requirements
- R1: After reset the acknowledge vector is zero, `busy_o` and `done_o` are low, and the first scan begins at slot 0.
- R2: Slot `i` belongs to controller `i[2]` as channel `i[1:0]`. Bit `i` of `mask_i`, `dreq_i`, `swreq_i` and `dack_o` refers to slot `i`. The mode of slot `i` is `mode_i[2i+1:2i]`, encoded as 00 demand, 01 single, 10 block and 11 cascade.
- R3: A scan examines one slot per clock, starting at the pointer. If it examines k slots, `done_o` rises on the k-th rising edge after the edge that sampled `start_i`. The pointer is then left one past the last slot examined, wrapping from 7 to 0.
- R4: When `ctrl_off_i[c]` is high, every slot of controller c is skipped. A skipped slot is never served and never has its acknowledge bit set.
- R5: A slot in cascade mode (11) is skipped even when its software request bit is set.
- R6: In single or block mode, a request that is present and unmasked (`dreq_i` set and `mask_i` clear) sets the slot's acknowledge bit when the slot is examined, and the slot is served.
- R7: In single or block mode, a slot whose acknowledge bit is already set is served without a live request if its mask bit is clear. It is not served if its mask bit is set.
- R8: In demand mode a slot is served exactly when its live `dreq_i` bit is set, regardless of its mask bit, and its acknowledge bit is never set.
- R9: A set `swreq_i` bit serves its slot regardless of request, acknowledge or mask.
- R10: A scan that finds nothing raises `done_o` with `found_o` low after eight cycles, and the pointer ends back at the start slot.
- R11: `tc_valid_i` clears acknowledge bit `tc_idx_i` on the next edge. A clear wins over a set of the same bit in the same cycle.
- R12: `done_o` is a one-cycle pulse. `grant_o` is high exactly in a `done_o` cycle where a slot was found. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| ctrl_off_i | input | 2 | Per-controller disable (command register bit 2) |
| mask_i | input | 8 | Per-slot request mask |
| swreq_i | input | 8 | Per-slot software request |
| dreq_i | input | 8 | Per-slot hardware request |
| mode_i | input | 16 | Two-bit mode per slot |
| tc_valid_i | input | 1 | Terminal count report |
| tc_idx_i | input | 3 | Slot the terminal count belongs to |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished (one cycle) |
| found_o | output | 1 | Last scan found a slot |
| grant_o | output | 1 | Service strobe for `sel_o` |
| sel_o | output | 3 | Selected slot index |
| dack_o | output | 8 | Per-slot acknowledge state |

## Verification
The bench targets the following corner cases.

- **Latched acknowledge with no live request.** It checks that a slot is still served later, after the request has been withdrawn. A design that gates on the live request alone would report nothing here.
- **Masking a latched slot.** It checks that masking such a slot stops service. A design that forgets the mask would keep granting it.
- **Demand mode.** A demand-mode slot that is masked must still be served and must leave no acknowledge bit behind.
- **Skips and the software override.** The bench checks that cascade slots and disabled controllers are skipped, even when a software request or a hardware request is present. It also checks that the software bit overrides the mask. A design that skips wrongly shows a wrong index or a wrong latency.
- **Collision and restart.** The bench makes a terminal count collide with the acknowledge set of the same slot. It also issues a restart pulse during a full empty lap. A design that lets the set win, or that restarts early, leaves a stale acknowledge or produces an extra done.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;

    typedef enum logic [1:0] {
        XFER_DEMAND  = 2'b00,
        XFER_SINGLE  = 2'b01,
        XFER_BLOCK   = 2'b10,
        XFER_CASCADE = 2'b11
    } xfer_mode_e;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_SCAN = 1'b1
    } sch_state_e;

endpackage

// File: rtl/dma_slot_eval.sv
module dma_slot_eval
    import dma_rr_pkg::*;
(
    input  logic       ctrl_off,
    input  logic [1:0] mode,
    input  logic       dreq,
    input  logic       mask,
    input  logic       swreq,
    input  logic       dack,
    output logic       serve,
    output logic       ack_req
);

    xfer_mode_e mode_e;
    logic       usable;
    logic       latched_kind;

    always_comb begin
        mode_e       = xfer_mode_e'(mode);
        usable       = !ctrl_off && (mode_e != XFER_CASCADE);
        latched_kind = (mode_e == XFER_SINGLE) || (mode_e == XFER_BLOCK);
        ack_req      = usable && latched_kind && dreq && !mask;
        serve        = 1'b0;
        if (usable) begin
            if (swreq) begin
                serve = 1'b1;
            end else if (mode_e == XFER_DEMAND) begin
                serve = dreq;
            end else begin
                serve = (dack || ack_req) && !mask;
            end
        end
    end

endmodule

// File: rtl/dma_ack_bank.sv
module dma_ack_bank #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_SLOTS-1:0] ack
);

    logic [NUM_SLOTS-1:0] ack_d, ack_q;

    always_comb begin
        ack_d = ack_q;
        if (set_en) ack_d[set_idx] = 1'b1;
        if (clr_en) ack_d[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign ack = ack_q;

endmodule

// File: rtl/dma_rr_sched.sv
module dma_rr_sched
    import dma_rr_pkg::*;
#(
    parameter int NUM_CTRL    = 2,
    parameter int CH_PER_CTRL = 4,
    localparam int NUM_SLOTS  = NUM_CTRL * CH_PER_CTRL,
    localparam int IDX_W      = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NUM_CTRL-1:0]    ctrl_off_i,
    input  logic [NUM_SLOTS-1:0]   mask_i,
    input  logic [NUM_SLOTS-1:0]   swreq_i,
    input  logic [NUM_SLOTS-1:0]   dreq_i,
    input  logic [2*NUM_SLOTS-1:0] mode_i,
    input  logic                   tc_valid_i,
    input  logic [IDX_W-1:0]       tc_idx_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   found_o,
    output logic                   grant_o,
    output logic [IDX_W-1:0]       sel_o,
    output logic [NUM_SLOTS-1:0]   dack_o
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

    typedef struct packed {
        sch_state_e       state;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] sel;
        logic             done;
        logic             found;
    } sch_regs_t;

    sch_regs_t            cur_q, nxt_d;
    logic [NUM_SLOTS-1:0] serve_vec;
    logic [NUM_SLOTS-1:0] ackreq_vec;
    logic [NUM_SLOTS-1:0] dack_w;
    logic [IDX_W-1:0]     ptr_inc;
    logic                 set_en;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        dma_slot_eval u_eval (
            .ctrl_off (ctrl_off_i[g / CH_PER_CTRL]),
            .mode     (mode_i[2*g +: 2]),
            .dreq     (dreq_i[g]),
            .mask     (mask_i[g]),
            .swreq    (swreq_i[g]),
            .dack     (dack_w[g]),
            .serve    (serve_vec[g]),
            .ack_req  (ackreq_vec[g])
        );
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        set_en     = 1'b0;
        ptr_inc    = (cur_q.ptr == LAST_SLOT) ? '0 : cur_q.ptr + 1'b1;
        case (cur_q.state)
            SCH_IDLE: begin
                if (start_i) begin
                    nxt_d.state = SCH_SCAN;
                    nxt_d.first = cur_q.ptr;
                end
            end
            SCH_SCAN: begin
                set_en    = ackreq_vec[cur_q.ptr];
                nxt_d.ptr = ptr_inc;
                if (serve_vec[cur_q.ptr]) begin
                    nxt_d.state = SCH_IDLE;
                    nxt_d.done  = 1'b1;
                    nxt_d.found = 1'b1;
                    nxt_d.sel   = cur_q.ptr;
                end else if (ptr_inc == cur_q.first) begin
                    nxt_d.state = SCH_IDLE;
                    nxt_d.done  = 1'b1;
                    nxt_d.found = 1'b0;
                end
            end
            default: nxt_d.state = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: SCH_IDLE, ptr: '0, first: '0, sel: '0,
                       done: 1'b0, found: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    dma_ack_bank #(.NUM_SLOTS(NUM_SLOTS)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (cur_q.ptr),
        .clr_en  (tc_valid_i),
        .clr_idx (tc_idx_i),
        .ack     (dack_w)
    );

    assign busy_o  = (cur_q.state == SCH_SCAN);
    assign done_o  = cur_q.done;
    assign found_o = cur_q.found;
    assign grant_o = cur_q.done && cur_q.found;
    assign sel_o   = cur_q.sel;
    assign dack_o  = dack_w;

endmodule

// File: rtl/dma_rr_sched_chk.sv
module dma_rr_sched_chk #(
    parameter int NUM_CTRL    = 2,
    parameter int CH_PER_CTRL = 4,
    localparam int NUM_SLOTS  = NUM_CTRL * CH_PER_CTRL,
    localparam int IDX_W      = $clog2(NUM_SLOTS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy_o,
    input logic                   done_o,
    input logic                   grant_o,
    input logic [IDX_W-1:0]       sel_o,
    input logic [NUM_SLOTS-1:0]   dack_o,
    input logic [NUM_CTRL-1:0]    ctrl_off_i,
    input logic [2*NUM_SLOTS-1:0] mode_i,
    input logic                   tc_valid_i,
    input logic [IDX_W-1:0]       tc_idx_i
);

    logic [NUM_CTRL-1:0]    off_p;
    logic [2*NUM_SLOTS-1:0] mode_p;
    logic [IDX_W:0]         lap_cnt;
    logic                   sel_off;
    logic [1:0]             sel_mode;

    always_ff @(posedge clk) begin
        off_p  <= ctrl_off_i;
        mode_p <= mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lap_cnt <= '0;
        else if (busy_o) lap_cnt <= lap_cnt + 1'b1;
        else             lap_cnt <= '0;
    end

    always_comb begin
        sel_off  = off_p[sel_o / IDX_W'(CH_PER_CTRL)];
        sel_mode = mode_p[2*sel_o +: 2];
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    // R4
    grant_ctrl_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !sel_off);

    // R5
    grant_not_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (sel_mode != 2'b11));

    // R11
    tc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_valid_i |=> !dack_o[$past(tc_idx_i)]);

    // R10
    lap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lap_cnt < (IDX_W+1)'(NUM_SLOTS)));

endmodule

bind dma_rr_sched dma_rr_sched_chk #(
    .NUM_CTRL    (NUM_CTRL),
    .CH_PER_CTRL (CH_PER_CTRL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .grant_o    (grant_o),
    .sel_o      (sel_o),
    .dack_o     (dack_o),
    .ctrl_off_i (ctrl_off_i),
    .mode_i     (mode_i),
    .tc_valid_i (tc_valid_i),
    .tc_idx_i   (tc_idx_i)
);

// File: tb/dma_rr_sched_tb.sv
module dma_rr_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  ctrl_off_i = '0;
    logic [7:0]  mask_i = '0;
    logic [7:0]  swreq_i = '0;
    logic [7:0]  dreq_i = '0;
    logic [15:0] mode_i = 16'h5555;
    logic        tc_valid_i = 1'b0;
    logic [2:0]  tc_idx_i = '0;
    logic        busy_o, done_o, found_o, grant_o;
    logic [2:0]  sel_o;
    logic [7:0]  dack_o;

    always #2 clk = ~clk;

    dma_rr_sched dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_off_i(ctrl_off_i),
        .mask_i(mask_i), .swreq_i(swreq_i), .dreq_i(dreq_i), .mode_i(mode_i),
        .tc_valid_i(tc_valid_i), .tc_idx_i(tc_idx_i), .busy_o(busy_o),
        .done_o(done_o), .found_o(found_o), .grant_o(grant_o), .sel_o(sel_o),
        .dack_o(dack_o)
    );

    typedef struct {
        bit          found;
        bit [2:0]    sel;
        int unsigned at;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          total = 0;
    int          bad = 0;
    int unsigned cyc = 0;
    int          done_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare at every done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R12 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(found_o == e.found, {e.req, " found"}, found_o, e.found);
                    check(grant_o == e.found, "R12 grant", grant_o, e.found);
                    if (e.found) check(sel_o == e.sel, {e.req, " sel"}, sel_o, e.sel);
                    check(cyc == e.at, "R3 latency", cyc, e.at);
                end
            end
        end
    end

    task automatic issue(input bit f, input bit [2:0] s, input int k, input string req);
        exp_t e;
        @(negedge clk);
        e.found = f; e.sel = s; e.at = cyc + 1 + k; e.req = req;
        sb_q.push_back(e);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_scan(input bit f, input bit [2:0] s, input int k, input string req);
        issue(f, s, k, req);
        drain();
    endtask

    task automatic pulse_tc(input bit [2:0] idx);
        @(negedge clk);
        tc_valid_i = 1'b1; tc_idx_i = idx;
        @(negedge clk);
        tc_valid_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dack_o == 8'h00, "R1 dack", dack_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 single-mode request on slot 3, from pointer 0 (R1, R2)
        dreq_i = 8'h08;
        run_scan(1'b1, 3'd3, 4, "R6");
        check(dack_o == 8'h08, "R6 dack set", dack_o, 8'h08);

        // R7 latched ack served without live request, pointer at 4 (R3)
        dreq_i = 8'h00;
        run_scan(1'b1, 3'd3, 8, "R7");

        // R7 masked latched slot not served; R10 empty lap
        mask_i = 8'h08;
        run_scan(1'b0, 3'd0, 8, "R10");
        check(dack_o == 8'h08, "R7 dack kept", dack_o, 8'h08);

        // R11 terminal count clears
        pulse_tc(3'd3);
        @(negedge clk);
        check(dack_o == 8'h00, "R11 tc clear", dack_o, 0);

        // R8 demand slot 5, masked, still served, no ack
        mask_i = 8'h20; dreq_i = 8'h20; mode_i = 16'h5155;
        run_scan(1'b1, 3'd5, 2, "R8");
        check(dack_o == 8'h00, "R8 no ack", dack_o, 0);

        // R5 cascade slot 6 skipped despite swreq; R9 swreq beats mask on 7
        mode_i = 16'h7555; swreq_i = 8'hC0; dreq_i = 8'h40; mask_i = 8'h80;
        run_scan(1'b1, 3'd7, 2, "R5 R9");
        check(dack_o == 8'h00, "R5 no ack on cascade", dack_o, 0);

        // R4 controller 0 disabled: slot 1 skipped, slot 6 found
        mode_i = 16'h5555; swreq_i = 8'h00; mask_i = 8'h00;
        ctrl_off_i = 2'b01; dreq_i = 8'h42;
        run_scan(1'b1, 3'd6, 7, "R4");
        check(dack_o == 8'h40, "R4 skipped slot no ack", dack_o, 8'h40);

        // R12 start while busy ignored during an empty lap from 7
        pulse_tc(3'd6);
        ctrl_off_i = 2'b00; dreq_i = 8'h00;
        base = done_cnt;
        issue(1'b0, 3'd0, 8, "R12");
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        repeat (12) @(negedge clk);
        check(done_cnt == base + 1, "R12 single done", done_cnt - base, 1);

        // R11 clear wins over set in the same cycle on slot 7
        dreq_i = 8'h80;
        issue(1'b1, 3'd7, 1, "R11");
        tc_valid_i = 1'b1; tc_idx_i = 3'd7;
        @(negedge clk);
        tc_valid_i = 1'b0;
        drain();
        check(dack_o == 8'h00, "R11 clear beats set", dack_o, 0);

        // R6 block mode on slot 2 from pointer 0
        mode_i = 16'h5565; dreq_i = 8'h04;
        run_scan(1'b1, 3'd2, 3, "R6 block");
        check(dack_o == 8'h04, "R6 block ack", dack_o, 8'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule